// File: doc/BRIEF.md
# Pulse-Based Zero Suppression Filter

This block thins out one event of front-end samples before it is moved further down a readout chain. An event holds a fixed number of timebins for every channel, and the samples arrive one per cycle with timebin as the outer index. For every timebin, all channels stream in ascending order before the next timebin starts. Each channel has its own 12-bit threshold, held in a small register file that a host loads through a simple write port before running.

While the event streams in, the block stores every sample and sets a per-channel hit flag when any sample of that channel rises above its threshold. After the last sample has been stored, the block walks the channels in ascending order. For each flagged channel it emits the complete waveform, all timebins in order, with every word tagged by its channel and timebin index. Channels without a hit produce no words. A closing word then reports how many channels were kept. With bypass asserted, every channel is treated as flagged.

Top module: `pzs_filter`

## Requirements
- R1: After reset, out_valid and out_end are both low until an event has been fully received.
- R2: A channel with at least one sample strictly above its threshold has all NTB samples emitted, with out_tb counting 0 to NTB-1 on consecutive words. Each word carries that channel's stored sample for that timebin.
- R3: A sample equal to its channel's threshold does not count as a hit.
- R4: A channel with no sample above its threshold produces no output words.
- R5: Kept channels are emitted in strictly ascending channel order within an event.
- R6: After the last data word of an event, out_end pulses high for exactly one cycle with out_valid low. In that cycle out_count equals the number of channels kept.
- R7: While bypass is high for a whole event, every channel is emitted and out_count equals NCH.
- R8: A write with thr_we high stores thr_data as the threshold of channel thr_addr only. A later write replaces it for subsequent events.
- R9: The k-th accepted sample of an event (k from 0) belongs to channel k mod NCH and timebin k / NCH. Its value reappears under that channel and timebin index.
- R10: An event in which no channel is hit and bypass is low produces only the end word, with out_count equal to 0.
- R11: Hit flags from one event do not carry into the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Keep every channel; hold stable for a whole event |
| thr_we | input | 1 | Threshold write strobe |
| thr_addr | input | CW (7) | Channel whose threshold is written |
| thr_data | input | DW (12) | Threshold value |
| in_valid | input | 1 | Input sample valid; ignored while an event is being emitted |
| in_sample | input | DW (12) | Input sample, timebin-major order |
| out_valid | output | 1 | Data word valid |
| out_chan | output | CW (7) | Channel index of the data word |
| out_tb | output | TW (3) | Timebin index of the data word |
| out_data | output | DW (12) | Sample value |
| out_end | output | 1 | One-cycle event-end word |
| out_count | output | KW (8) | Number of kept channels, valid with out_end |

## Verification
A stale or missed hit flag shows up as a whole channel appearing or vanishing in the output stream. The scoreboard catches it at the first word of the wrong channel, or at the end word through a wrong count. A wrong buffer address or timebin counter corrupts the data or tag of a kept word, which is flagged on that word. A stuck drain walk either breaks the ascending order, which the embedded properties catch in the next cycle, or never produces the end word, which stalls the event and fails it.

// File: rtl/pzs_pkg.sv
package pzs_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_FINISH  = 2'd2
  } pzs_state_e;
endpackage

// File: rtl/pzs_thr_file.sv
// Per-channel threshold storage: one write port for the host, one
// registered read port for the compare stage (block-RAM friendly).
module pzs_thr_file #(
  parameter int NCH = 128,
  parameter int DW  = 12,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [CW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pzs_sample_buf.sv
// Event sample buffer: simple dual-port memory with a registered read.
module pzs_sample_buf #(
  parameter int DEPTH = 896,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // R9: the timebin-major write address never leaves the buffer
  a_r9_waddr_range: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH));
  a_r2_raddr_range: assert property (@(posedge clk) disable iff (rst)
    re |-> (int'(raddr) < DEPTH));
endmodule

// File: rtl/pzs_filter.sv
module pzs_filter
  import pzs_pkg::*;
#(
  parameter int NCH = 128,
  parameter int NTB = 7,
  parameter int DW  = 12,
  localparam int CW    = $clog2(NCH),
  localparam int TW    = $clog2(NTB),
  localparam int KW    = $clog2(NCH + 1),
  localparam int DEPTH = NCH * NTB,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bypass,
  input  logic          thr_we,
  input  logic [CW-1:0] thr_addr,
  input  logic [DW-1:0] thr_data,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  output logic          out_valid,
  output logic [CW-1:0] out_chan,
  output logic [TW-1:0] out_tb,
  output logic [DW-1:0] out_data,
  output logic          out_end,
  output logic [KW-1:0] out_count
);
  localparam logic [CW-1:0] CH_LAST = CW'(NCH - 1);
  localparam logic [TW-1:0] TB_LAST = TW'(NTB - 1);

  pzs_state_e    state_q;
  logic [CW-1:0] in_ch_q;
  logic [TW-1:0] in_tb_q;

  // stage 1: sample registered alongside its threshold read
  logic          v1_q;
  logic [CW-1:0] ch1_q;
  logic [TW-1:0] tb1_q;
  logic [DW-1:0] smp1_q;
  logic [DW-1:0] thr_rd;

  logic [NCH-1:0] hit_q;
  logic [CW-1:0]  oc_q;
  logic [TW-1:0]  otb_q;
  logic [KW-1:0]  kept_q;

  logic          last1, accept, is_hit, keep_now, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;

  assign last1    = v1_q && (ch1_q == CH_LAST) && (tb1_q == TB_LAST);
  assign accept   = in_valid && (state_q == ST_COLLECT) && !last1;
  assign is_hit   = v1_q && (smp1_q > thr_rd);
  assign wr_addr  = AW'(tb1_q) * AW'(NCH) + AW'(ch1_q);
  assign keep_now = hit_q[oc_q] | bypass;
  assign rd_en    = (state_q == ST_DRAIN) && keep_now;
  assign rd_addr  = AW'(otb_q) * AW'(NCH) + AW'(oc_q);

  pzs_thr_file #(.NCH(NCH), .DW(DW)) thr_i (
    .clk  (clk),
    .we   (thr_we),
    .waddr(thr_addr),
    .wdata(thr_data),
    .raddr(in_ch_q),
    .rdata(thr_rd)
  );

  pzs_sample_buf #(.DEPTH(DEPTH), .DW(DW)) buf_i (
    .clk  (clk),
    .rst  (rst),
    .we   (v1_q),
    .waddr(wr_addr),
    .wdata(smp1_q),
    .re   (rd_en),
    .raddr(rd_addr),
    .rdata(out_data)
  );

  // ingest: timebin-major position counters and stage-1 register
  always_ff @(posedge clk) begin
    if (rst) begin
      in_ch_q <= '0;
      in_tb_q <= '0;
      v1_q    <= 1'b0;
      ch1_q   <= '0;
      tb1_q   <= '0;
      smp1_q  <= '0;
    end else begin
      v1_q <= accept;
      if (accept) begin
        ch1_q  <= in_ch_q;
        tb1_q  <= in_tb_q;
        smp1_q <= in_sample;
        if (in_ch_q == CH_LAST) begin
          in_ch_q <= '0;
          in_tb_q <= (in_tb_q == TB_LAST) ? '0 : in_tb_q + TW'(1);
        end else begin
          in_ch_q <= in_ch_q + CW'(1);
        end
      end
    end
  end

  // per-channel hit flags, accumulated over all timebins of the event
  always_ff @(posedge clk) begin
    if (rst || state_q == ST_FINISH) hit_q <= '0;
    else if (is_hit)                 hit_q[ch1_q] <= 1'b1;
  end

  // drain walk and registered output tags
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_COLLECT;
      oc_q      <= '0;
      otb_q     <= '0;
      kept_q    <= '0;
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_tb    <= '0;
      out_end   <= 1'b0;
      out_count <= '0;
    end else begin
      out_end <= 1'b0;
      case (state_q)
        ST_COLLECT: begin
          out_valid <= 1'b0;
          if (last1) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          out_valid <= keep_now;
          out_chan  <= oc_q;
          out_tb    <= otb_q;
          if (keep_now && otb_q != TB_LAST) begin
            otb_q <= otb_q + TW'(1);
          end else begin
            otb_q <= '0;
            if (keep_now) kept_q <= kept_q + KW'(1);
            if (oc_q == CH_LAST) begin
              oc_q    <= '0;
              state_q <= ST_FINISH;
            end else begin
              oc_q <= oc_q + CW'(1);
            end
          end
        end
        default: begin
          out_valid <= 1'b0;
          out_end   <= 1'b1;
          out_count <= kept_q;
          kept_q    <= '0;
          state_q   <= ST_COLLECT;
        end
      endcase
    end
  end

  // R1: nothing leaves the block until an event is complete
  a_r1_quiet_collect: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COLLECT && !$past(state_q == ST_FINISH)) |-> !out_valid && !out_end);
  // R2: timebins of a kept channel follow each other without gaps
  a_r2_tb_sequence: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tb != '0) |->
      $past(out_valid) && out_chan == $past(out_chan) && out_tb == $past(out_tb) + TW'(1));
  a_r2_tb_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_tb) < NTB));
  // R5: a new waveform always starts on a higher channel
  a_r5_ascending: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_tb == '0 && $past(out_valid)) |-> out_chan > $past(out_chan));
  // R6: end word stands alone, lasts one cycle, and is bounded
  a_r6_end_alone: assert property (@(posedge clk) disable iff (rst)
    out_end |-> !out_valid && (int'(out_count) <= NCH));
  a_r6_end_pulse: assert property (@(posedge clk) disable iff (rst)
    out_end |=> !out_end);
  // R7: with bypass held, every channel is counted
  a_r7_bypass_all: assert property (@(posedge clk) disable iff (rst)
    (out_end && bypass && $past(bypass)) |-> (int'(out_count) == NCH));
endmodule

// File: tb/pzs_filter_tb_top.sv
module pzs_filter_tb_top;
  localparam int NCH = 128;
  localparam int NTB = 7;
  localparam int DW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bypass = 1'b0;
  logic          thr_we = 1'b0;
  logic [6:0]    thr_addr = '0;
  logic [DW-1:0] thr_data = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_sample = '0;
  logic          out_valid;
  logic [6:0]    out_chan;
  logic [2:0]    out_tb;
  logic [DW-1:0] out_data;
  logic          out_end;
  logic [7:0]    out_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] smp [NTB][NCH];
  logic [DW-1:0] thr [NCH];
  logic [22:0]   exp_q [$];
  string         tag_q [$];

  always #2 clk = ~clk;

  pzs_filter #(.NCH(NCH), .NTB(NTB), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .bypass(bypass),
    .thr_we(thr_we), .thr_addr(thr_addr), .thr_data(thr_data),
    .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_chan(out_chan), .out_tb(out_tb),
    .out_data(out_data), .out_end(out_end), .out_count(out_count)
  );

  task automatic check(input bit ok, input string tag, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: pop and compare each output word
  always @(negedge clk) begin
    if (!rst && (out_valid || out_end)) begin
      logic [22:0] got;
      got = out_end ? {1'b1, 7'd0, 3'd0, 4'd0, out_count} : {1'b0, out_chan, out_tb, out_data};
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected word", got, '0);
      end else begin
        logic [22:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == e && !(out_valid && out_end), t, got, e);
      end
    end
  end

  task automatic write_thr();
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      thr_we = 1'b1; thr_addr = 7'(c); thr_data = thr[c];
    end
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic fill_base(input int ev);
    for (int t = 0; t < NTB; t++)
      for (int c = 0; c < NCH; c++)
        smp[t][c] = 12'((c * 37 + t * 11 + ev * 5) % 256 + 100);
  endtask

  // driver: model the expected stream, then send the event
  task automatic run_event(input string tag);
    int kept = 0;
    for (int c = 0; c < NCH; c++) begin
      bit h = bypass;
      for (int t = 0; t < NTB; t++) if (smp[t][c] > thr[c]) h = 1'b1;
      if (h) begin
        kept++;
        for (int t = 0; t < NTB; t++) begin
          exp_q.push_back({1'b0, 7'(c), 3'(t), smp[t][c]});
          tag_q.push_back({tag, " R2 R5 R9 data"});
        end
      end
    end
    exp_q.push_back({1'b1, 7'd0, 3'd0, 4'd0, 8'(kept)});
    tag_q.push_back({tag, " R6 end count"});
    for (int t = 0; t < NTB; t++)
      for (int c = 0; c < NCH; c++) begin
        @(negedge clk);
        in_valid = 1'b1; in_sample = smp[t][c];
      end
    @(negedge clk);
    in_valid = 1'b0;
    for (int w = 0; w < 3000 && exp_q.size() != 0; w++) @(negedge clk);
    check(exp_q.size() == 0, {tag, " R6 event completed"}, 23'(exp_q.size()), '0);
    exp_q.delete();
    tag_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_end, "R1 reset outputs", {21'd0, out_valid, out_end}, '0);

    // event 1: isolated hits, equality case, per-channel thresholds (R3 R4 R8)
    for (int c = 0; c < NCH; c++) thr[c] = 12'd4095;
    thr[0] = 12'd2000; thr[5] = 12'd2000; thr[20] = 12'd2000;
    thr[64] = 12'd150; thr[127] = 12'd3999;
    write_thr();
    fill_base(0);
    smp[2][0] = 12'd2001;
    smp[6][5] = 12'd3000;
    smp[3][20] = 12'd2000;   // equal: R3 no hit
    smp[0][127] = 12'd4000;
    run_event("E1 R3 R4 R8");

    // event 2: no hits, flags from event 1 must be gone (R10 R11)
    thr[64] = 12'd4095;
    write_thr();
    fill_base(1);
    run_event("E2 R10 R11");

    // event 3: bypass keeps everything (R7)
    bypass = 1'b1;
    fill_base(2);
    run_event("E3 R7");
    bypass = 1'b0;

    // event 4: zero thresholds keep every channel
    for (int c = 0; c < NCH; c++) thr[c] = 12'd0;
    write_thr();
    fill_base(3);
    run_event("E4 R2 R8");

    // event 5: mixed pattern with a common threshold
    for (int c = 0; c < NCH; c++) thr[c] = 12'd330;
    write_thr();
    fill_base(4);
    run_event("E5 R2 R4 R5");

    finish_run();
  end
endmodule